// File: doc/BRIEF.md
# Shared-Buffer Per-Output Queue Router Input Port

This block is one input port of a mesh router. Every flit that arrives from the upstream link is written into a single pool of buffer slots. The slot it lands in is taken from a list of free slot numbers. The number of that slot is then appended to a small queue kept for the output direction the flit must leave by. Storage is therefore not split into fixed per-output partitions: one busy direction may use every slot, and a quiet direction uses none.

Routing is done one hop ahead. A head flit already carries the output direction it takes at this router. When the crossbar arbiter grants an output, the unit does three things in the same cycle: it reads the oldest slot of that output's queue, works out the direction the flit must take at the next router using XY dimension order, and returns the slot to the free list. The flit, with its direction field rewritten for the next hop, appears on the output register one cycle later.

Back-pressure rules on the upstream stream are as follows. `in_ready` is high whenever at least one slot is free. A flit moves on any rising edge where `in_valid` and `in_ready` are both high. A sender that raises `in_valid` keeps the same flit until it is taken. The downstream side has no ready signal: the arbiter's grant is the permission to send. The arbiter must grant at most one output per cycle, and only an output whose request is high.

Top module: `voq_input_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, `in_ready` is 1, `out_req` is all zero and `out_valid` is 0.
- R2: A flit is made of the following fields, from the most significant bit down: kind (2 bits), direction (3 bits), destination x (CW bits), destination y (CW bits) and data (DW bits). It is stored on each rising edge where `in_valid` and `in_ready` are both 1, and at no other time.
- R3: `in_ready` is 0 exactly when all DEPTH slots hold flits. While it is 0, no flit is accepted.
- R4: The kind codes are 01 for head, 11 for a single-flit packet, 00 for body and 10 for tail (kind bit 0 set means the flit carries a route). A head or single-flit packet is queued for the direction in its own direction field. A body or tail flit is queued for the direction of the most recently accepted head.
- R5: `out_req[p]` is 1 exactly when the queue for direction p holds at least one flit. Any single direction can hold all DEPTH flits.
- R6: A grant on direction p in cycle t makes `out_valid` 1 in cycle t+1. In that cycle `out_port` is p and `out_flit` is the oldest flit queued for p. Flits of one direction leave in the order they arrived.
- R7: Direction codes are 0 local, 1 north (y+1), 2 east (x+1), 3 south (y-1) and 4 west (x-1). For a head or single-flit packet leaving by p, the direction field is replaced by the XY route from the neighbour reached through p to the destination: east if the destination x is greater, west if it is smaller, otherwise north or south by y, and local when both coordinates match. Body and tail flits leave unchanged.
- R8: A slot freed by a grant can be used again from the next cycle. A grant made while the pool is full raises `in_ready` in the next cycle.
- R9: `out_valid` is 0 in every cycle that does not follow a grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_x | input | CW | X coordinate of this router |
| cur_y | input | CW | Y coordinate of this router |
| in_valid | input | 1 | Upstream flit valid |
| in_ready | output | 1 | A free slot exists, so a flit can be taken |
| in_flit | input | 5+2*CW+DW | Upstream flit |
| out_req | output | 5 | Per-direction request: that queue is non-empty |
| out_grant | input | 5 | Per-direction grant from the crossbar arbiter, one-hot or zero |
| out_valid | output | 1 | Output flit valid |
| out_port | output | 3 | Direction the output flit was granted on |
| out_flit | output | 5+2*CW+DW | Output flit, route field updated for the next hop |

## Verification
A lost or duplicated slot number shows first on `in_ready`. A leaked slot makes the port report full while the model still sees free space. A duplicated slot lets two queued flits share storage, so one of them comes out with the other's contents. A queue pointer or a packet-direction register that goes wrong shows up at the next grant on that direction, as a wrong or out-of-order flit. It can also show up earlier, as an `out_req` bit that disagrees with the model in the very cycle after the bad write. A faulty next-hop route shows on the first head flit that leaves, one cycle after its grant.

// File: rtl/voq_pkg.sv
package voq_pkg;
  localparam int NPORT = 5;
  localparam int PW    = 3;

  // direction codes; the next-hop route logic depends on this order
  typedef enum logic [PW-1:0] {
    DIR_LOCAL = 3'd0,
    DIR_NORTH = 3'd1,
    DIR_EAST  = 3'd2,
    DIR_SOUTH = 3'd3,
    DIR_WEST  = 3'd4
  } dir_e;

  // flit kinds: bit 0 set means the flit carries a route
  localparam logic [1:0] KIND_BODY = 2'b00;
  localparam logic [1:0] KIND_HEAD = 2'b01;
  localparam logic [1:0] KIND_TAIL = 2'b10;
  localparam logic [1:0] KIND_SOLO = 2'b11;

  function automatic logic carries_route(input logic [1:0] kind);
    return kind[0];
  endfunction
endpackage

// File: rtl/vq_fifo.sv
module vq_fifo #(
  parameter int W        = 4,
  parameter int DEPTH    = 16,
  parameter bit INIT_SEQ = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH+1);

  logic [W-1:0]    mem [DEPTH];
  logic [PTRW-1:0] wp, rp;

  function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH-1)) ? '0 : p + PTRW'(1);
  endfunction

  assign dout  = mem[rp];
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= INIT_SEQ ? CNTW'(DEPTH) : '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT_SEQ ? W'(i) : '0;
    end else begin
      if (push) begin
        mem[wp] <= din;
        wp      <= bump(wp);
      end
      if (pop) rp <= bump(rp);
      count <= count + CNTW'(push) - CNTW'(pop);
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNTW'(DEPTH)) |-> !(push && !pop));
  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
endmodule

// File: rtl/nexthop_rc.sv
module nexthop_rc
  import voq_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic [CW-1:0] cur_x,
  input  logic [CW-1:0] cur_y,
  input  logic [PW-1:0] hop,
  input  logic [CW-1:0] dst_x,
  input  logic [CW-1:0] dst_y,
  output logic [PW-1:0] next_dir
);
  logic [CW-1:0] nx, ny;

  always_comb begin
    nx = cur_x;
    ny = cur_y;
    case (hop)
      DIR_NORTH: ny = cur_y + CW'(1);
      DIR_EAST:  nx = cur_x + CW'(1);
      DIR_SOUTH: ny = cur_y - CW'(1);
      DIR_WEST:  nx = cur_x - CW'(1);
      default: ;
    endcase
    if (dst_x > nx)      next_dir = DIR_EAST;
    else if (dst_x < nx) next_dir = DIR_WEST;
    else if (dst_y > ny) next_dir = DIR_NORTH;
    else if (dst_y < ny) next_dir = DIR_SOUTH;
    else                 next_dir = DIR_LOCAL;
  end
endmodule

// File: rtl/voq_input_unit.sv
module voq_input_unit
  import voq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = 3,
  parameter int DW    = 16,
  localparam int FW   = 2 + PW + 2*CW + DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    cur_x,
  input  logic [CW-1:0]    cur_y,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [FW-1:0]    in_flit,
  output logic [NPORT-1:0] out_req,
  input  logic [NPORT-1:0] out_grant,
  output logic             out_valid,
  output logic [PW-1:0]    out_port,
  output logic [FW-1:0]    out_flit
);
  localparam int SW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH+1);
  localparam int PLO  = DW + 2*CW;

  logic [FW-1:0]   slot_mem [DEPTH];
  logic [SW-1:0]   free_slot, rd_slot;
  logic            free_empty;
  logic [CNTW-1:0] free_cnt;
  logic            accept, any_grant, in_head;
  logic [PW-1:0]   target, pkt_dir, gidx, nxt_dir;
  logic [FW-1:0]   rd_flit, fwd_flit;

  logic [NPORT-1:0] aq_push, aq_empty;
  logic [SW-1:0]    aq_head [NPORT];
  logic [CNTW-1:0]  aq_cnt  [NPORT];

  assign in_ready  = !free_empty;
  assign accept    = in_valid && in_ready;
  assign in_head   = carries_route(in_flit[FW-1 -: 2]);
  assign target    = in_head ? in_flit[PLO +: PW] : pkt_dir;
  assign any_grant = |out_grant;

  // slot numbers not in use
  vq_fifo #(.W(SW), .DEPTH(DEPTH), .INIT_SEQ(1'b1)) u_free (
    .clk(clk), .rst_n(rst_n),
    .push(any_grant), .din(rd_slot),
    .pop(accept), .dout(free_slot),
    .empty(free_empty), .count(free_cnt)
  );

  // one slot-number queue per direction
  for (genvar p = 0; p < NPORT; p++) begin : g_aq
    assign aq_push[p] = accept && (target == PW'(p));
    assign out_req[p] = !aq_empty[p];
    vq_fifo #(.W(SW), .DEPTH(DEPTH), .INIT_SEQ(1'b0)) u_aq (
      .clk(clk), .rst_n(rst_n),
      .push(aq_push[p]), .din(free_slot),
      .pop(out_grant[p]), .dout(aq_head[p]),
      .empty(aq_empty[p]), .count(aq_cnt[p])
    );
  end

  always_comb begin
    rd_slot = '0;
    gidx    = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (out_grant[p]) begin
        rd_slot = rd_slot | aq_head[p];
        gidx    = PW'(p);
      end
    end
  end

  assign rd_flit = slot_mem[rd_slot];

  nexthop_rc #(.CW(CW)) u_rc (
    .cur_x(cur_x), .cur_y(cur_y), .hop(gidx),
    .dst_x(rd_flit[DW+CW +: CW]), .dst_y(rd_flit[DW +: CW]),
    .next_dir(nxt_dir)
  );

  always_comb begin
    fwd_flit = rd_flit;
    if (carries_route(rd_flit[FW-1 -: 2])) fwd_flit[PLO +: PW] = nxt_dir;
  end

  always_ff @(posedge clk) begin
    if (accept) slot_mem[free_slot] <= in_flit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_dir   <= DIR_LOCAL;
      out_valid <= 1'b0;
      out_port  <= '0;
      out_flit  <= '0;
    end else begin
      if (accept && in_head) pkt_dir <= in_flit[PLO +: PW];
      out_valid <= any_grant;
      if (any_grant) begin
        out_port <= gidx;
        out_flit <= fwd_flit;
      end
    end
  end

  int occupancy;
  always_comb begin
    occupancy = int'(free_cnt);
    for (int p = 0; p < NPORT; p++) occupancy += int'(aq_cnt[p]);
  end

  // R8
  slot_conservation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy == DEPTH);
  // R6
  grant_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_grant) && ((out_grant & ~out_req) == '0));
  // R9
  out_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_grant |=> out_valid);
  // R9
  out_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_grant |=> !out_valid);
  // R4
  head_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_head) |-> (in_flit[PLO +: PW] < PW'(NPORT)));
endmodule

// File: tb/sim_voq_input_unit.sv
module sim_voq_input_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int CW    = 3;
  localparam int DW    = 16;
  localparam int NP    = 5;
  localparam int FW    = 5 + 2*CW + DW;
  localparam int PLO   = DW + 2*CW;
  localparam int MX    = 3;
  localparam int MY    = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] cur_x = CW'(MX), cur_y = CW'(MY);
  logic in_valid = 1'b0, in_ready;
  logic [FW-1:0] in_flit = '0;
  logic [NP-1:0] out_req, out_grant = '0;
  logic out_valid;
  logic [2:0] out_port;
  logic [FW-1:0] out_flit;

  voq_input_unit #(.DEPTH(DEPTH), .CW(CW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cur_x(cur_x), .cur_y(cur_y),
    .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
    .out_req(out_req), .out_grant(out_grant),
    .out_valid(out_valid), .out_port(out_port), .out_flit(out_flit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  logic [FW-1:0] mq [NP][$];
  int mcur = 0;
  bit ev = 0;
  int ep = 0;
  logic [FW-1:0] ef = '0;
  int errors = 0, checks = 0;
  bit done = 0;

  // packet generator state
  int pk_left = 0, pk_len = 0, pk_port = 0, pk_dx = 0, pk_dy = 0, dcnt = 0;
  bit pend = 0;
  logic [FW-1:0] pend_f = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int total();
    int s = 0;
    for (int p = 0; p < NP; p++) s += mq[p].size();
    return s;
  endfunction

  function automatic int xy_dir(input int x, input int y, input int dx, input int dy);
    if (dx > x) return 2;
    if (dx < x) return 4;
    if (dy > y) return 1;
    if (dy < y) return 3;
    return 0;
  endfunction

  function automatic logic [FW-1:0] expect_out(input logic [FW-1:0] f, input int g);
    logic [FW-1:0] r = f;
    int nx = MX, ny = MY;
    if (f[FW-2]) begin
      if (g == 1) ny++;
      if (g == 2) nx++;
      if (g == 3) ny--;
      if (g == 4) nx--;
      r[PLO +: 3] = 3'(xy_dir(nx, ny, int'(f[DW+CW +: CW]), int'(f[DW +: CW])));
    end
    return r;
  endfunction

  task automatic compare();
    chk(in_ready == (total() < DEPTH), "R3 in_ready vs pool fill", 64'(in_ready), 64'(total() < DEPTH));
    for (int p = 0; p < NP; p++)
      chk(out_req[p] == (mq[p].size() > 0), "R5 out_req", 64'(out_req[p]), 64'(mq[p].size() > 0));
    chk(out_valid == ev, "R9 out_valid", 64'(out_valid), 64'(ev));
    if (ev) begin
      chk(int'(out_port) == ep, "R6 out_port", 64'(out_port), 64'(ep));
      chk(out_flit == ef, ef[FW-2] ? "R7 head next-hop route" : "R6 flit order and contents",
          64'(out_flit), 64'(ef));
    end
  endtask

  task automatic step(input bit v, input logic [FW-1:0] f, input int g, output bit acc);
    int ge;
    @(negedge clk);
    compare();
    ge = (g >= 0 && mq[g].size() > 0) ? g : -1;
    in_valid  = v;
    in_flit   = f;
    out_grant = (ge >= 0) ? NP'(1 << ge) : '0;
    acc = v && (total() < DEPTH);
    ev = (ge >= 0);
    if (ev) begin
      ep = ge;
      ef = expect_out(mq[ge].pop_front(), ge);
    end
    if (acc) begin
      if (f[FW-2]) begin
        mcur = int'(f[PLO +: 3]);
        mq[mcur].push_back(f);
      end else begin
        mq[mcur].push_back(f);
      end
    end
    @(posedge clk);
  endtask

  task automatic next_flit(input int fixed_port);
    logic [1:0] k;
    if (pk_left == 0) begin
      pk_len  = 1 + ($urandom % 4);
      pk_left = pk_len;
      pk_port = (fixed_port >= 0) ? fixed_port : ($urandom % 5);
      pk_dx   = $urandom % 8;
      pk_dy   = $urandom % 8;
    end
    if (pk_len == 1)           k = 2'b11;
    else if (pk_left == pk_len) k = 2'b01;
    else if (pk_left == 1)     k = 2'b10;
    else                       k = 2'b00;
    pk_left--;
    dcnt++;
    pend_f = {k, 3'(pk_port), CW'(pk_dx), CW'(pk_dy), DW'(dcnt)};
    pend = 1;
  endtask

  task automatic pick_grant(input int gprob, output int g);
    int cand [$];
    g = -1;
    if (($urandom % 100) < gprob) begin
      for (int p = 0; p < NP; p++) if (mq[p].size() > 0) cand.push_back(p);
      if (cand.size() > 0) g = cand[$urandom % cand.size()];
    end
  endtask

  task automatic run(input int n, input int vprob, input int gprob, input int fixed_port);
    bit a;
    int g;
    for (int i = 0; i < n; i++) begin
      if (!pend && (($urandom % 100) < vprob)) next_flit(fixed_port);
      pick_grant(gprob, g);
      step(pend, pend_f, g, a);
      if (a) pend = 0;
    end
  endtask

  task automatic flush();
    while (pk_left > 0 || pend) run(1, 100, 100, -1);
    run(2 * DEPTH + 4, 0, 100, -1);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog expired actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    bit a;
    int g;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(in_ready == 1'b1, "R1 in_ready in reset", 64'(in_ready), 64'd1);
    chk(out_req == '0, "R1 out_req in reset", 64'(out_req), 64'd0);
    chk(out_valid == 1'b0, "R1 out_valid in reset", 64'(out_valid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk(in_ready == 1'b1 && out_req == '0 && !out_valid, "R1 first cycle after reset",
        64'({in_ready, out_req, out_valid}), 64'({1'b1, 5'b0, 1'b0}));

    // R2 R3: fill the pool with no grants
    run(DEPTH + 8, 100, 0, -1);
    #1;
    chk(in_ready == 1'b0, "R3 pool full drops in_ready", 64'(in_ready), 64'd0);

    // R8: grant while full, the freed slot is usable next cycle
    pick_grant(100, g);
    step(pend, pend_f, g, a);
    if (a) pend = 0;
    #1;
    chk(in_ready == 1'b1, "R8 grant while full frees a slot", 64'(in_ready), 64'd1);
    step(pend, pend_f, -1, a);
    if (a) pend = 0;
    #1;
    chk(a == 1'b1 && in_ready == 1'b0, "R8 freed slot reused", 64'({a, in_ready}), 64'({1'b1, 1'b0}));

    flush();

    // R4 R5: every packet aimed at east, all slots in one queue
    run(DEPTH + 12, 100, 0, 2);
    #1;
    chk(out_req == 5'b00100, "R4 R5 single direction holds all flits", 64'(out_req), 64'h4);
    chk(in_ready == 1'b0, "R5 one queue holds DEPTH flits", 64'(in_ready), 64'd0);
    flush();

    // R6 R7: mixed traffic under varying load
    run(3000, 60, 50, -1);
    run(2000, 90, 30, -1);
    run(1000, 40, 90, -1);
    flush();

    done = 1;
    summary();
    $finish;
  end
endmodule